// File: doc/BRIEF.md
# Multi-Mode Serial Test Pattern Generator

This block sits ahead of a serializing transmitter and hands it one parallel word per clock. A 3-bit mode input picks the word's source. Mode zero passes user data straight through. The other modes produce a test pattern: one of four pseudo-random bit sequences of different lengths, a word-aligned link compliance symbol stream, or one of two square waves. The word holds 16 or 20 bits, set at build time. Bit 0 of each word is the first bit to go out on the serial line.

To check that a receiver notices bit errors, an error-injection input flips one bit of the pattern on every cycle it is high. A static select picks the source of that error request. It can come from the external input, or from the error flag of a remote pattern checker. With the checker as the source, the block can close a jitter-tolerance loop without crossing clock domains. Whenever the mode changes, the pattern restarts from a known state, so the first word after a mode switch is always the same.

Top module: `test_pattern_gen`

## Requirements
- R1: With `mode_sel` = 000, `tx_word` equals the `user_data` sampled on the previous rising edge. `force_err` and `chk_err` have no effect on it.
- R2: With `mode_sel` = 001, `tx_word` carries the PRBS-7 sequence from x^7+x^6+1. The generator uses a Fibonacci register: each new bit is the XOR of the bits generated 7 and 6 steps earlier. The register advances by the full word width every cycle, and bit 0 holds the earliest bit.
- R3: With `mode_sel` = 010, 011 or 100, `tx_word` carries PRBS-15 (x^15+x^14+1), PRBS-23 (x^23+x^18+1) or PRBS-31 (x^31+x^28+1). Bit order and advance are the same as in R2.
- R4: With `mode_sel` = 101 and a 20-bit word, `tx_word` alternates between 20'h5557C and 20'hAAA83, starting with 20'h5557C. These words hold the 10-bit symbols K28.5 with negative disparity (10'h17C), D21.5 (10'h155), K28.5 with positive disparity (10'h283) and D10.2 (10'h2AA), in that order. The first symbol of each word is in bits 9:0, and the first serial bit of a symbol is in its bit 0.
- R5: With `mode_sel` = 101 and a 16-bit word, `tx_word` is all zeros.
- R6: With `mode_sel` = 110, `tx_word` alternates 0 and 1 from bit 0 upward, with bit 0 = 0. This gives 20'hAAAAA or 16'hAAAA.
- R7: With `mode_sel` = 111, the lower half of `tx_word` is 0 and the upper half is 1. This gives 20'hFFC00 or 16'hFF00, a square wave whose period is the word width.
- R8: In any non-zero mode, `tx_word` bit 0 is inverted on each cycle that the effective error request is high, and every other bit is left alone. The injection does not change the pattern state, so later words are unaffected.
- R9: With `loop_chk_err` = 1, the effective error request is `chk_err` and `force_err` is ignored. With `loop_chk_err` = 0, it is `force_err` and `chk_err` is ignored.
- R10: Each change of `mode_sel` restarts the pattern. The shift register is reloaded with all ones, and the compliance phase returns to its first word.
- R11: While `rst_n` is low, `tx_word` is zero. The mode is treated as 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Pattern select |
| user_data | input | WORD_W | Data sent in mode 000 |
| force_err | input | 1 | External error-injection request |
| chk_err | input | 1 | Error flag from a remote pattern checker |
| loop_chk_err | input | 1 | Static select: 1 means `chk_err` drives error injection |
| tx_word | output | WORD_W | Registered word to the serializer, bit 0 first |

## Verification
Every result arrives on `tx_word` one rising edge after the inputs that produced it. This holds for pass-through data, each pattern word, an injected error and the restart after a mode change, because there is a single output register and nothing else in the path. The bench drives inputs on the falling edge and queues the expected word. A monitor takes the word from the queue one nanosecond after the next rising edge, so each comparison lands exactly one cycle after its stimulus. A second instance with 16-bit words is checked at that same point for the width-dependent modes.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [2:0] {
    TPG_PASS  = 3'd0,
    TPG_PN7   = 3'd1,
    TPG_PN15  = 3'd2,
    TPG_PN23  = 3'd3,
    TPG_PN31  = 3'd4,
    TPG_COMPL = 3'd5,
    TPG_SQ2   = 3'd6,
    TPG_SQW   = 3'd7
  } tpg_mode_e;

  localparam int unsigned LFSR_MAX = 31;

  typedef struct packed {
    logic [4:0] len;
    logic [4:0] tap;
  } lfsr_cfg_t;

  // Register length and second tap for each PRBS mode
  function automatic lfsr_cfg_t lfsr_cfg(input logic [2:0] mode);
    lfsr_cfg_t c;
    case (mode)
      TPG_PN15: begin c.len = 5'd15; c.tap = 5'd14; end
      TPG_PN23: begin c.len = 5'd23; c.tap = 5'd18; end
      TPG_PN31: begin c.len = 5'd31; c.tap = 5'd28; end
      default:  begin c.len = 5'd7;  c.tap = 5'd6;  end
    endcase
    return c;
  endfunction

  // One serial step: new bit enters at bit 0, register masked to len bits
  function automatic logic [LFSR_MAX-1:0] lfsr_step(input logic [LFSR_MAX-1:0] s,
                                                    input lfsr_cfg_t c);
    logic nb;
    logic [LFSR_MAX-1:0] m;
    nb = s[c.len - 5'd1] ^ s[c.tap - 5'd1];
    m  = '0;
    for (int j = 0; j < LFSR_MAX; j++)
      if (j < int'(c.len)) m[j] = 1'b1;
    return {s[LFSR_MAX-2:0], nb} & m;
  endfunction

  function automatic logic is_prbs(input logic [2:0] mode);
    return (mode >= TPG_PN7) && (mode <= TPG_PN31);
  endfunction

  // Compliance symbols in send order, first serial bit in bit 0
  function automatic logic [9:0] compl_sym(input logic [1:0] idx);
    case (idx)
      2'd0:    return 10'h17C;
      2'd1:    return 10'h155;
      2'd2:    return 10'h283;
      default: return 10'h2AA;
    endcase
  endfunction

endpackage

// File: rtl/tpg_prbs_core.sv
module tpg_prbs_core
  import tpg_pkg::*;
#(
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [2:0]        mode,
  output logic [WORD_W-1:0] prbs_word
);

  logic [LFSR_MAX-1:0] lfsr_q;
  logic [LFSR_MAX-1:0] lfsr_nxt;
  lfsr_cfg_t           cfg;

  assign cfg = lfsr_cfg(mode);

  always_comb begin
    logic [LFSR_MAX-1:0] st;
    st = restart ? {LFSR_MAX{1'b1}} : lfsr_q;
    prbs_word = '0;
    for (int i = 0; i < int'(WORD_W); i++) begin
      st = lfsr_step(st, cfg);
      prbs_word[i] = st[0];
    end
    lfsr_nxt = st;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= {LFSR_MAX{1'b1}};
    else        lfsr_q <= lfsr_nxt;
  end

endmodule

// File: rtl/tpg_fixed_pat.sv
module tpg_fixed_pat
  import tpg_pkg::*;
#(
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [2:0]        mode,
  output logic [WORD_W-1:0] fix_word
);

  localparam int unsigned HALF_W = WORD_W / 2;

  logic              phase_q;
  logic              phase_cur;
  logic [WORD_W-1:0] compl_word;
  logic [WORD_W-1:0] sq2_word;
  logic [WORD_W-1:0] sqw_word;

  assign phase_cur = restart ? 1'b0 : phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_cur;
  end

  generate
    if (WORD_W == 20) begin : g_compl20
      assign compl_word = {compl_sym({phase_cur, 1'b1}), compl_sym({phase_cur, 1'b0})};
    end else begin : g_compl_none
      assign compl_word = '0;
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < int'(WORD_W); i++) begin
      sq2_word[i] = (i % 2) == 1;
      sqw_word[i] = i >= int'(HALF_W);
    end
  end

  always_comb begin
    case (mode)
      TPG_COMPL: fix_word = compl_word;
      TPG_SQ2:   fix_word = sq2_word;
      TPG_SQW:   fix_word = sqw_word;
      default:   fix_word = '0;
    endcase
  end

endmodule

// File: rtl/tpg_err_inject.sv
module tpg_err_inject
  import tpg_pkg::*;
#(
  parameter int unsigned WORD_W = 20
) (
  input  logic              loop_sel,
  input  logic              force_err,
  input  logic              chk_err,
  input  logic [2:0]        mode,
  input  logic [WORD_W-1:0] pat_word,
  input  logic [WORD_W-1:0] user_data,
  output logic              eff_err,
  output logic [WORD_W-1:0] out_word
);

  assign eff_err = loop_sel ? chk_err : force_err;

  always_comb begin
    if (mode == TPG_PASS) out_word = user_data;
    else                  out_word = pat_word ^ {{(WORD_W-1){1'b0}}, eff_err};
  end

endmodule

// File: rtl/test_pattern_gen.sv
module test_pattern_gen
  import tpg_pkg::*;
#(
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic [WORD_W-1:0] user_data,
  input  logic              force_err,
  input  logic              chk_err,
  input  logic              loop_chk_err,
  output logic [WORD_W-1:0] tx_word
);

  logic [2:0]        mode_q;
  logic              mode_chg;
  logic              eff_err;
  logic [WORD_W-1:0] prbs_word;
  logic [WORD_W-1:0] fix_word;
  logic [WORD_W-1:0] pat_word;
  logic [WORD_W-1:0] out_word;

  assign mode_chg = mode_sel != mode_q;

  tpg_prbs_core #(.WORD_W(WORD_W)) u_prbs (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (mode_chg),
    .mode      (mode_sel),
    .prbs_word (prbs_word)
  );

  tpg_fixed_pat #(.WORD_W(WORD_W)) u_fixed (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (mode_chg),
    .mode     (mode_sel),
    .fix_word (fix_word)
  );

  assign pat_word = is_prbs(mode_sel) ? prbs_word : fix_word;

  tpg_err_inject #(.WORD_W(WORD_W)) u_err (
    .loop_sel  (loop_chk_err),
    .force_err (force_err),
    .chk_err   (chk_err),
    .mode      (mode_sel),
    .pat_word  (pat_word),
    .user_data (user_data),
    .eff_err   (eff_err),
    .out_word  (out_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= TPG_PASS;
      tx_word <= '0;
    end else begin
      mode_q  <= mode_sel;
      tx_word <= out_word;
    end
  end

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int unsigned WORD_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_sel,
  input logic [WORD_W-1:0] user_data,
  input logic [WORD_W-1:0] tx_word,
  input logic [WORD_W-1:0] pat_word,
  input logic              eff_err,
  input logic              mode_chg,
  input logic              loop_chk_err,
  input logic              force_err,
  input logic              chk_err
);

  function automatic logic [WORD_W-1:0] sq2_ref();
    logic [WORD_W-1:0] w;
    for (int i = 0; i < int'(WORD_W); i++) w[i] = i[0];
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] sqw_ref();
    logic [WORD_W-1:0] w;
    for (int i = 0; i < int'(WORD_W); i++) w[i] = (2 * i >= int'(WORD_W));
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] compl_first();
    return (WORD_W == 20) ? WORD_W'(32'h5557C) : '0;
  endfunction

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd0) |=> tx_word == $past(user_data)); // R1

  AST_ERR_BIT0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 3'd0) |=> tx_word[WORD_W-1:1] == $past(pat_word[WORD_W-1:1])); // R8

  AST_ERR_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 3'd0 && eff_err) |=> tx_word[0] != $past(pat_word[0])); // R8

  AST_LOOP_MASKS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_chk_err && !chk_err && force_err) |-> !eff_err); // R9

  AST_EXT_MASKS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_chk_err && !force_err && chk_err) |-> !eff_err); // R9

  AST_SQ2_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd6 && !eff_err) |=> tx_word == sq2_ref()); // R6

  AST_SQW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd7 && !eff_err) |=> tx_word == sqw_ref()); // R7

  AST_COMPL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd5 && mode_chg && !eff_err) |=> tx_word == compl_first()); // R10

endmodule

bind test_pattern_gen tpg_checker #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_sel     (mode_sel),
  .user_data    (user_data),
  .tx_word      (tx_word),
  .pat_word     (pat_word),
  .eff_err      (eff_err),
  .mode_chg     (mode_chg),
  .loop_chk_err (loop_chk_err),
  .force_err    (force_err),
  .chk_err      (chk_err)
);

// File: tb/sim_test_pattern_gen.sv
`timescale 1ns/1ps
module sim_test_pattern_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic [19:0] user_data = '0;
  logic        force_err = 1'b0;
  logic        chk_err = 1'b0;
  logic        loop_chk_err = 1'b0;
  logic [19:0] tx_word;
  logic [15:0] tx_word16;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  test_pattern_gen #(.WORD_W(20)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .user_data(user_data),
    .force_err(force_err), .chk_err(chk_err), .loop_chk_err(loop_chk_err),
    .tx_word(tx_word)
  );

  test_pattern_gen #(.WORD_W(16)) u1 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .user_data(user_data[15:0]),
    .force_err(force_err), .chk_err(chk_err), .loop_chk_err(loop_chk_err),
    .tx_word(tx_word16)
  );

  // Reference model state: bit history, newest bit first
  bit       hist [0:30];
  bit       ph = 1'b0;
  bit [2:0] prev_mode = 3'd0;

  logic [19:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input bit [2:0] m, input bit eff, input bit [19:0] ud,
                       output bit [19:0] exp);
    bit [19:0] clean;
    int n, k;
    clean = '0;
    if (m != prev_mode) begin
      for (int j = 0; j < 31; j++) hist[j] = 1'b1;
      ph = 1'b0;
    end
    case (m)
      3'd1: begin n = 7;  k = 6;  end
      3'd2: begin n = 15; k = 14; end
      3'd3: begin n = 23; k = 18; end
      default: begin n = 31; k = 28; end
    endcase
    if (m >= 3'd1 && m <= 3'd4) begin
      for (int i = 0; i < 20; i++) begin
        bit nb;
        nb = hist[n-1] ^ hist[k-1];
        for (int j = 30; j > 0; j--) hist[j] = hist[j-1];
        hist[0] = nb;
        clean[i] = nb;
      end
    end else if (m == 3'd5) begin
      clean = ph ? 20'hAAA83 : 20'h5557C;
    end else if (m == 3'd6) begin
      clean = 20'hAAAAA;
    end else if (m == 3'd7) begin
      clean = 20'hFFC00;
    end
    ph = ~ph;
    exp = (m == 3'd0) ? ud : (clean ^ {19'd0, eff});
    prev_mode = m;
  endtask

  task automatic step(input bit [2:0] m, input bit fe, input bit ce, input bit lp,
                      input bit [19:0] ud, input string tag);
    bit [19:0] e;
    @(negedge clk);
    mode_sel = m; force_err = fe; chk_err = ce; loop_chk_err = lp; user_data = ud;
    model(m, lp ? ce : fe, ud, e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: each queued word is due one rising edge after it was driven
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [19:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, tx_word, e);
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int j = 0; j < 31; j++) hist[j] = 1'b1;
    user_data = 20'h12345;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset word 20-bit", tx_word, 20'h0);
    check("R11 reset word 16-bit", {4'h0, tx_word16}, 20'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: pass-through, error inputs ignored
    step(3'd0, 1'b0, 1'b0, 1'b0, 20'hA5A5A, "R1 pass");
    step(3'd0, 1'b1, 1'b0, 1'b0, 20'h0F0F1, "R1 pass force_err ignored");
    step(3'd0, 1'b0, 1'b1, 1'b1, 20'hFFFFF, "R1 pass chk_err ignored");
    step(3'd0, 1'b1, 1'b1, 1'b0, 20'h00001, "R1 pass both errors");

    // R2 with R8 injections
    for (int c = 0; c < 40; c++)
      step(3'd1, (c == 5) || (c == 6) || (c == 20), 1'b0, 1'b0, 20'h0,
           ((c == 5) || (c == 6) || (c == 20)) ? "R8 prbs7 injected" : "R2 prbs7");

    // R3
    for (int c = 0; c < 30; c++) step(3'd2, 1'b0, 1'b0, 1'b0, 20'h0, "R3 prbs15");
    for (int c = 0; c < 30; c++) step(3'd3, c == 10, 1'b0, 1'b0, 20'h0, "R3 prbs23");
    for (int c = 0; c < 30; c++) step(3'd4, 1'b0, 1'b0, 1'b0, 20'h0, "R3 prbs31");

    // R4 compliance, R5 zeros on the 16-bit instance
    for (int c = 0; c < 6; c++) step(3'd5, 1'b0, 1'b0, 1'b0, 20'h0, "R4 compliance");
    @(posedge clk); #2;
    check("R5 compliance 16-bit zeros", {4'h0, tx_word16}, 20'h0);
    step(3'd5, 1'b1, 1'b0, 1'b0, 20'h0, "R8 compliance injected");

    // R6, R7 on both widths
    for (int c = 0; c < 3; c++) step(3'd6, 1'b0, 1'b0, 1'b0, 20'h0, "R6 square 2UI");
    @(posedge clk); #2;
    check("R6 square 2UI 16-bit", {4'h0, tx_word16}, 20'h0AAAA);
    for (int c = 0; c < 3; c++) step(3'd7, 1'b0, 1'b0, 1'b0, 20'h0, "R7 square word period");
    @(posedge clk); #2;
    check("R7 square word period 16-bit", {4'h0, tx_word16}, 20'h0FF00);
    step(3'd7, 1'b1, 1'b0, 1'b0, 20'h0, "R8 square injected");

    // R9: loopback select
    for (int c = 0; c < 4; c++) step(3'd1, 1'b1, 1'b0, 1'b1, 20'h0, "R9 loop ignores force_err");
    for (int c = 0; c < 2; c++) step(3'd1, 1'b0, 1'b1, 1'b1, 20'h0, "R9 loop uses chk_err");
    for (int c = 0; c < 2; c++) step(3'd1, 1'b0, 1'b1, 1'b0, 20'h0, "R9 external ignores chk_err");

    // R10: restarts on mode change
    for (int c = 0; c < 5; c++) step(3'd1, 1'b0, 1'b0, 1'b0, 20'h0, "R10 prbs7 restart");
    step(3'd6, 1'b0, 1'b0, 1'b0, 20'h0, "R10 interlude");
    for (int c = 0; c < 3; c++) step(3'd1, 1'b0, 1'b0, 1'b0, 20'h0, "R10 prbs7 reseeded");
    for (int c = 0; c < 3; c++) step(3'd5, 1'b0, 1'b0, 1'b0, 20'h0, "R10 compliance phase");
    step(3'd7, 1'b0, 1'b0, 1'b0, 20'h0, "R10 interlude");
    for (int c = 0; c < 2; c++) step(3'd5, 1'b0, 1'b0, 1'b0, 20'h0, "R10 compliance rephased");
    step(3'd0, 1'b0, 1'b0, 1'b0, 20'h13579, "R1 pass after patterns");

    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end

endmodule